// File: doc/BRIEF.md
# Sequential Round-Subkey Expander

This block turns a 128-bit user key into the seventeen 128-bit round subkeys of a SAFER+-style block cipher. It hands them out one at a time, in order, from a small working store. It does not hold all seventeen subkeys at once. The store has seventeen octets: the sixteen key octets plus a check octet, which is the XOR of those sixteen.

Each step rotates every octet of the store left by three bits and moves the whole store down by one octet position. The next subkey is then the first sixteen octets of the store, each added mod 256 to the matching octet of a bias word. The bias words are constants that the block computes when it is elaborated.

A round datapath loads a key with `load_key` and then pulses `next` each time it needs the following subkey. The current subkey stays on `subkey` until the next step or the next load.

Top module: `skx_top`

## Requirements
- R1: After reset, `valid` is 0 and `subkey` is all zeros, and both stay that way until a load.
- R2: A cycle with `load_key` high makes `valid` 1 from the next cycle. In that cycle `subkey` equals the sampled `key_in` with no bias added; this is subkey 1.
- R3: The 17th store octet is the XOR of the sixteen key octets. It enters the output first as octet 15 of subkey 2.
- R4: Octet 0 is bits [127:120] of `key_in` and of `subkey`, and octet j is bits [127-8j -: 8]. Subkey i, for i = 2..17, has octet j (0..15) equal to rotl(k[(i-1+j) mod 17], 3(i-1) mod 8) + B(i,j) mod 256. Here k[16] is the check octet.
- R5: Let E(x) = (45^x mod 257) mod 256. The bias octet B(i,j) is E(E((17i+j+1) mod 256)).
- R6: While `load_key` and `next` are both low, `subkey` and `valid` do not change.
- R7: A `next` pulse while subkey 17 is presented has no effect. `subkey` stays at subkey 17 until the next load.
- R8: `load_key` restarts the sequence at subkey 1 at any point. It takes priority over a `next` in the same cycle.
- R9: A `next` pulse before the first load has no effect. `valid` stays 0 and `subkey` stays zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_key | input | 1 | Capture `key_in` and present subkey 1 |
| key_in | input | 128 | User key, octet 0 in the top bits |
| next | input | 1 | Advance to the following subkey |
| subkey | output | 128 | Current round subkey |
| valid | output | 1 | A key is loaded and `subkey` is meaningful |

## Verification
The hardest state to reach from the ports is the end of the sequence. There, further `next` pulses must leave subkey 17 untouched, and that state only exists after sixteen advances from a fresh load. The bench walks a full sequence, then keeps pulsing `next` and compares against subkey 17 computed in software. It also reloads in the middle of a sequence, and raises `load_key` and `next` in the same cycle, to show that the restart wins. Keys with all-zero and all-one octets are used, so that the check octet and the rotation can be told apart from the bias addition.

// File: rtl/skx_pkg.sv
package skx_pkg;
  localparam int OCTETS  = 16;
  localparam int SLOTS   = OCTETS + 1;
  localparam int SUBKEYS = SLOTS;
  localparam int KEY_W   = 8 * OCTETS;
  localparam int IDX_W   = $clog2(SUBKEYS + 1);
  localparam int ROM_W   = (SUBKEYS - 1) * KEY_W;

  typedef logic [7:0] octet_t;
  typedef octet_t [SLOTS-1:0] store_t;

  function automatic octet_t rotl8(input octet_t x, input int r);
    logic [15:0] d;
    d = {x, x};
    return d[15-r -: 8];
  endfunction

  // Bias words for subkeys 2..SUBKEYS, word (i-2) at offset (i-2)*KEY_W,
  // octet j of a word at bits [KEY_W-1-8j -: 8].
  function automatic logic [ROM_W-1:0] build_bias();
    logic [255:0][7:0] ex;
    logic [ROM_W-1:0]  rom;
    int acc;
    acc = 1;
    for (int x = 0; x < 256; x++) begin
      ex[x] = acc[7:0];
      acc   = (acc * 45) % 257;
    end
    rom = '0;
    for (int i = 2; i <= SUBKEYS; i++) begin
      for (int j = 0; j < OCTETS; j++) begin
        rom[(i-2)*KEY_W + KEY_W-1-8*j -: 8] = ex[ex[(17*i + j + 1) % 256]];
      end
    end
    return rom;
  endfunction
endpackage

// File: rtl/skx_fold.sv
module skx_fold
  import skx_pkg::*;
(
  input  logic [KEY_W-1:0] key,
  output octet_t           parity
);
  always_comb begin
    parity = '0;
    for (int j = 0; j < OCTETS; j++) begin
      parity = parity ^ key[KEY_W-1-8*j -: 8];
    end
  end
endmodule

// File: rtl/skx_step.sv
module skx_step
  import skx_pkg::*;
#(
  parameter int ROT = 3
) (
  input  store_t cur,
  output store_t nxt
);
  for (genvar p = 0; p < SLOTS; p++) begin : g_slot
    assign nxt[p] = rotl8(cur[(p + 1) % SLOTS], ROT);
  end
endmodule

// File: rtl/skx_mix.sv
module skx_mix
  import skx_pkg::*;
(
  input  store_t             cur,
  input  logic [IDX_W-1:0]   idx,
  output logic [KEY_W-1:0]   mixed
);
  localparam logic [ROM_W-1:0] BIAS_ROM = build_bias();

  logic [KEY_W-1:0] bias;

  always_comb begin
    bias = '0;
    for (int k = 2; k <= SUBKEYS; k++) begin
      if (idx == IDX_W'(k)) bias = BIAS_ROM[(k-2)*KEY_W +: KEY_W];
    end
  end

  for (genvar j = 0; j < OCTETS; j++) begin : g_add
    assign mixed[KEY_W-1-8*j -: 8] = cur[j] + bias[KEY_W-1-8*j -: 8];
  end
endmodule

// File: rtl/skx_top.sv
module skx_top
  import skx_pkg::*;
#(
  parameter int ROT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_key,
  input  logic [KEY_W-1:0] key_in,
  input  logic             next,
  output logic [KEY_W-1:0] subkey,
  output logic             valid
);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(SUBKEYS);

  store_t             store_q, store_d, store_adv, store_ld;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic               valid_q, valid_d;
  logic               store_en, advance;
  octet_t             parity;
  logic [KEY_W-1:0]   mixed;

  skx_fold u_fold (.key(key_in), .parity(parity));

  skx_step #(.ROT(ROT)) u_step (.cur(store_q), .nxt(store_adv));

  skx_mix u_mix (.cur(store_q), .idx(idx_q), .mixed(mixed));

  always_comb begin
    for (int p = 0; p < OCTETS; p++) begin
      store_ld[p] = key_in[KEY_W-1-8*p -: 8];
    end
    store_ld[SLOTS-1] = parity;
  end

  assign advance = valid_q && next && (idx_q < LAST_IDX);

  always_comb begin
    store_d  = store_q;
    idx_d    = idx_q;
    valid_d  = valid_q;
    store_en = 1'b0;
    if (load_key) begin
      store_d  = store_ld;
      idx_d    = FIRST_IDX;
      valid_d  = 1'b1;
      store_en = 1'b1;
    end else if (advance) begin
      store_d  = store_adv;
      idx_d    = idx_q + FIRST_IDX;
      store_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (store_en) begin
      store_q <= store_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign subkey = valid_q ? mixed : '0;
  assign valid  = valid_q;
endmodule

// File: rtl/skx_chk.sv
module skx_chk
  import skx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             load_key,
  input logic             next,
  input logic [KEY_W-1:0] key_in,
  input logic [KEY_W-1:0] subkey,
  input logic             valid,
  input logic [IDX_W-1:0] idx
);
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> subkey == '0);

  // R2
  load_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_key |=> valid && subkey == $past(key_in) && idx == IDX_W'(1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_key && !next) |=> $stable(subkey) && $stable(valid));

  // R7
  end_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && idx == IDX_W'(SUBKEYS) && !load_key) |=> $stable(subkey) && idx == IDX_W'(SUBKEYS));

  // R4
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && next && !load_key && idx < IDX_W'(SUBKEYS)) |=> idx == $past(idx) + IDX_W'(1));

  // R9
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !load_key) |=> !valid);

  // R4
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (idx >= IDX_W'(1) && idx <= IDX_W'(SUBKEYS)));
endmodule

bind skx_top skx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_key(load_key), .next(next),
  .key_in(key_in), .subkey(subkey), .valid(valid), .idx(idx_q)
);

// File: tb/skx_top_tb.sv
module skx_top_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_key = 1'b0;
  logic [127:0] key_in = '0;
  logic         next = 1'b0;
  logic [127:0] subkey;
  logic         valid;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  skx_top u_dut (.clk(clk), .rst_n(rst_n), .load_key(load_key), .key_in(key_in),
                 .next(next), .subkey(subkey), .valid(valid));

  function automatic logic [7:0] e45(input int x);
    int a;
    a = 1;
    for (int n = 0; n < (x % 256); n++) a = (a * 45) % 257;
    return a[7:0];
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int s);
    return (s == 0) ? v : ((v << s) | (v >> (8 - s)));
  endfunction

  function automatic logic [127:0] model(input logic [127:0] k, input int i);
    logic [7:0] o [0:16];
    logic [127:0] r;
    o[16] = '0;
    for (int j = 0; j < 16; j++) begin
      o[j]  = k[127-8*j -: 8];
      o[16] = o[16] ^ o[j];
    end
    if (i == 1) return k;
    for (int j = 0; j < 16; j++) begin
      r[127-8*j -: 8] = rl(o[(i-1+j) % 17], (3*(i-1)) % 8)
                        + e45(e45((17*i + j + 1) % 256));
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_load(input logic [127:0] k);
    @(negedge clk); load_key = 1'b1; key_in = k;
    @(negedge clk); load_key = 1'b0;
  endtask

  task automatic do_next();
    next = 1'b1;
    @(negedge clk); next = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", {127'd0, valid}, 128'd0);
    chk("R1 subkey after reset", subkey, 128'd0);
  endtask

  task automatic t_next_early();
    @(negedge clk); do_next();
    repeat (2) @(negedge clk);
    chk("R9 valid after early next", {127'd0, valid}, 128'd0);
    chk("R9 subkey after early next", subkey, 128'd0);
  endtask

  task automatic t_sequence(input logic [127:0] k);
    do_load(k);
    chk("R2 valid after load", {127'd0, valid}, 128'd1);
    chk("R2 raw first subkey", subkey, k);
    for (int i = 2; i <= 17; i++) begin
      do_next();
      chk((i == 2) ? "R3 R4 R5 subkey 2" : "R4 R5 subkey", subkey, model(k, i));
    end
  endtask

  task automatic t_hold(input logic [127:0] k);
    do_load(k);
    do_next(); do_next();
    repeat (6) @(negedge clk);
    chk("R6 hold subkey 3", subkey, model(k, 3));
    chk("R6 hold valid", {127'd0, valid}, 128'd1);
  endtask

  task automatic t_end(input logic [127:0] k);
    do_load(k);
    for (int i = 2; i <= 17; i++) do_next();
    chk("R7 reached subkey 17", subkey, model(k, 17));
    for (int n = 0; n < 3; n++) do_next();
    chk("R7 next past end ignored", subkey, model(k, 17));
    chk("R7 valid past end", {127'd0, valid}, 128'd1);
  endtask

  task automatic t_reload(input logic [127:0] a, input logic [127:0] b);
    do_load(a);
    for (int n = 0; n < 4; n++) do_next();
    chk("R8 before reload", subkey, model(a, 5));
    do_load(b);
    chk("R8 reload restarts", subkey, b);
    do_next();
    chk("R8 after reload step", subkey, model(b, 2));
    @(negedge clk); load_key = 1'b1; next = 1'b1; key_in = a;
    @(negedge clk); load_key = 1'b0; next = 1'b0;
    chk("R8 load beats next", subkey, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks + 1, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_next_early();
    t_sequence(128'h0);
    t_sequence({128{1'b1}});
    t_sequence(128'h000102030405060708090a0b0c0d0e0f);
    t_sequence(128'h0123456789abcdeffedcba9876543210);
    t_sequence(128'h80000000000000000000000000000001);
    t_hold(128'hdeadbeef00112233445566778899aabb);
    t_end(128'hf0e1d2c3b4a5968778695a4b3c2d1e0f);
    t_reload(128'h11111111222222223333333344444444, 128'hcafef00d0badc0de5555aaaa12345678);
    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule